// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry input, and gives a 16-bit sum and a carry output. It is purely combinational. No carry ripples from bit to bit. Each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). The operands are split into four 4-bit groups. A lookahead generator in each group forms that group's internal carries as flat sum-of-products terms, together with a group generate and a group propagate.

A second lookahead unit uses the same 4-bit equations on the four group generate/propagate pairs. It produces the carry into each group and the final carry-out. This keeps every product term to at most five inputs. The alternative, one flat expansion across all 16 bits, needs terms as wide as the word. The block is meant to sit inside a wider datapath wherever a single-cycle 16-bit addition with a short carry path is needed.

Top module: `cla_adder16`

## Requirements
- R1: For every input combination, {carry_out, sum} equals the 17-bit value op_a + op_b + carry_in, with both operands unsigned.
- R2: Within a 4-bit group, the carry into bit i+1 is set exactly when bit i generates, or when bit i propagates and its own carry-in is set (for example, 0x0003 + 0x0001 gives 0x0004).
- R3: A group whose four bits generate a carry passes it to the next group, whatever that group's carry-in is (for example, 0x000F + 0x0001 gives 0x0010).
- R4: The carry into group k (bit position 4k, for k = 1, 2, 3) equals the carry out of adding the low 4k bits of both operands and carry_in. At the ports this shows as sum[4k] XOR op_a[4k] XOR op_b[4k].
- R5: Each sum bit is the XOR of the two operand bits and its carry. It is cleared when both operand bits are set and the carry is clear. For example, 0x5555 + 0x5555 gives 0xAAAA with no carry-out.
- R6: When every bit propagates and none generates, carry_in reaches carry_out through all four groups. 0xFFFF + 0x0000 + 1 gives sum 0x0000 with carry_out 1, and 0x5555 + 0xAAAA + 1 gives the same.
- R7: Zero operands with carry_in clear give sum 0 and carry_out 0. Zero operands with carry_in set give sum 1 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the addition |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Immediate assertions are evaluated on every change of the inputs. They check that each group's flat carries obey the bit-level recurrence, and that each group's own carry-out matches the group generate/propagate relation. They also check that the second-level carries match both the group-level recurrence and the carries each group forms internally, and that the full result equals the arithmetic sum. Only the bench scenarios show the end-to-end effects at the ports: a carry-in crossing all four groups, group generates firing into the next group, and the XOR-versus-OR distinction in the sum. The bench also checks the per-group carries it recovers from the sum bits against a behavioural addition of the low bits.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Width handled by one lookahead generator
  localparam int LA_W = 4;

  typedef struct packed {
    logic [LA_W:0] carry;     // carry[0] is the carry in
    logic          grp_gen;
    logic          grp_prop;
  } la_out_t;

  function automatic logic [LA_W-1:0] bit_gen(input logic [LA_W-1:0] x,
                                              input logic [LA_W-1:0] y);
    return x & y;
  endfunction

  function automatic logic [LA_W-1:0] bit_prop(input logic [LA_W-1:0] x,
                                               input logic [LA_W-1:0] y);
    return x | y;
  endfunction

  // Half-sum kept apart from propagate, since propagate is the OR
  function automatic logic [LA_W-1:0] bit_half(input logic [LA_W-1:0] x,
                                               input logic [LA_W-1:0] y);
    return x ^ y;
  endfunction

  // Flat lookahead: every carry is a sum of products of g, p and cin
  function automatic la_out_t lookahead(input logic [LA_W-1:0] g,
                                        input logic [LA_W-1:0] p,
                                        input logic            cin);
    la_out_t r;
    logic    prod;
    r          = '0;
    r.carry[0] = cin;
    for (int i = 0; i < LA_W; i++) begin
      r.carry[i+1] = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = g[j];
        for (int k = j + 1; k <= i; k++) prod = prod & p[k];
        r.carry[i+1] = r.carry[i+1] | prod;
      end
      prod = cin;
      for (int k = 0; k <= i; k++) prod = prod & p[k];
      r.carry[i+1] = r.carry[i+1] | prod;
    end
    r.grp_gen = 1'b0;
    for (int j = 0; j < LA_W; j++) begin
      prod = g[j];
      for (int k = j + 1; k < LA_W; k++) prod = prod & p[k];
      r.grp_gen = r.grp_gen | prod;
    end
    r.grp_prop = &p;
    return r;
  endfunction

endpackage

// File: rtl/cla_group4.sv
module cla_group4
  import cla_pkg::*;
(
  input  logic [LA_W-1:0] a_in,
  input  logic [LA_W-1:0] b_in,
  input  logic            c_in,
  output logic [LA_W-1:0] sum_out,
  output logic            grp_gen,
  output logic            grp_prop,
  output logic            c_last
);

  logic [LA_W-1:0] gen_w;
  logic [LA_W-1:0] prop_w;
  logic [LA_W-1:0] half_w;
  la_out_t         la_w;
  logic [LA_W:0]   carry_w;

  always_comb begin
    gen_w   = bit_gen(a_in, b_in);
    prop_w  = bit_prop(a_in, b_in);
    half_w  = bit_half(a_in, b_in);
    la_w    = lookahead(gen_w, prop_w, c_in);
    carry_w = la_w.carry;
  end

  assign sum_out  = half_w ^ carry_w[LA_W-1:0];
  assign grp_gen  = la_w.grp_gen;
  assign grp_prop = la_w.grp_prop;
  assign c_last   = carry_w[LA_W];

  // R2: flat carries agree with the bit-level recurrence
  always_comb begin
    for (int i = 0; i < LA_W; i++) begin
      assert_carry_chain_R2: assert (carry_w[i+1] ==
                                     (gen_w[i] | (prop_w[i] & carry_w[i])))
        else $error("carry chain mismatch at bit %0d", i);
    end
  end

  // R3: group carry-out agrees with group generate/propagate
  always_comb begin
    assert_group_out_R3: assert (c_last == (grp_gen | (grp_prop & c_in)))
      else $error("group carry-out disagrees with group G/P");
  end

endmodule

// File: rtl/cla_level2.sv
module cla_level2
  import cla_pkg::*;
(
  input  logic [LA_W-1:0] grp_g,
  input  logic [LA_W-1:0] grp_p,
  input  logic            c_in,
  output logic [LA_W:0]   grp_carry
);

  la_out_t top_w;

  always_comb begin
    top_w     = lookahead(grp_g, grp_p, c_in);
    grp_carry = top_w.carry;
  end

  // R4: second-level carries follow the group recurrence
  always_comb begin
    for (int k = 0; k < LA_W; k++) begin
      assert_group_chain_R4: assert (grp_carry[k+1] ==
                                     (grp_g[k] | (grp_p[k] & grp_carry[k])))
        else $error("second-level carry mismatch at group %0d", k);
    end
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
(
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  output logic [15:0] sum,
  output logic        carry_out
);

  localparam int NUM_GROUPS = LA_W;
  localparam int WIDTH      = NUM_GROUPS * LA_W;

  logic [NUM_GROUPS-1:0] grp_g_w;
  logic [NUM_GROUPS-1:0] grp_p_w;
  logic [NUM_GROUPS-1:0] grp_last_w;
  logic [NUM_GROUPS:0]   grp_carry_w;
  logic [WIDTH-1:0]      sum_w;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    cla_group4 u_grp (
      .a_in    (op_a[k*LA_W +: LA_W]),
      .b_in    (op_b[k*LA_W +: LA_W]),
      .c_in    (grp_carry_w[k]),
      .sum_out (sum_w[k*LA_W +: LA_W]),
      .grp_gen (grp_g_w[k]),
      .grp_prop(grp_p_w[k]),
      .c_last  (grp_last_w[k])
    );
  end

  cla_level2 u_top (
    .grp_g    (grp_g_w),
    .grp_p    (grp_p_w),
    .c_in     (carry_in),
    .grp_carry(grp_carry_w)
  );

  assign sum       = sum_w;
  assign carry_out = grp_carry_w[NUM_GROUPS];

  // R4: each group's own carry-out matches the second-level carry
  always_comb begin
    for (int k = 0; k < NUM_GROUPS; k++) begin
      assert_carry_match_R4: assert (grp_last_w[k] == grp_carry_w[k+1])
        else $error("group %0d internal carry-out differs from level two", k);
    end
  end

  // R1: full result equals the arithmetic sum
  always_comb begin
    assert_sum_value_R1: assert ({carry_out, sum} ==
                                 ({1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in}))
      else $error("sum mismatch");
  end

endmodule

// File: tb/sim_cla_adder16.sv
module sim_cla_adder16;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cla_adder16 u0 (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum      (sum),
    .carry_out(carry_out)
  );

  // Drive at the falling edge, compare a quarter period after the rising edge
  task automatic run_vec(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input string tag);
    int exp_full;
    int got_full;
    int mask;
    int low_sum;
    int exp_c;
    int got_c;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    @(posedge clk);
    #(PERIOD/4);
    exp_full = int'(a) + int'(b) + int'(ci);
    got_full = {15'd0, carry_out, sum};
    checks++;
    if (got_full != exp_full) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d got=%h expected=%h",
               tag, a, b, ci, got_full, exp_full);
    end
    // R4: carry into each upper group recovered from the sum bits
    for (int k = 1; k < 4; k++) begin
      mask    = (1 << (4 * k)) - 1;
      low_sum = (int'(a) & mask) + (int'(b) & mask) + int'(ci);
      exp_c   = (low_sum >> (4 * k)) & 1;
      got_c   = int'(sum[4*k] ^ a[4*k] ^ b[4*k]);
      checks++;
      if (got_c != exp_c) begin
        errors++;
        $display("FAIL R4: group %0d carry a=%h b=%h cin=%0d got=%0d expected=%0d",
                 k, a, b, ci, got_c, exp_c);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish got=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    // Idle state after start-up (R7)
    run_vec(16'h0000, 16'h0000, 1'b0, "R7 zero");
    run_vec(16'h0000, 16'h0000, 1'b1, "R7 carry-in only");
    // In-group carries (R2)
    run_vec(16'h0003, 16'h0001, 1'b0, "R2 in-group");
    run_vec(16'h0300, 16'h0100, 1'b1, "R2 in-group upper");
    // Group generate (R3)
    run_vec(16'h000F, 16'h0001, 1'b0, "R3 group0 generate");
    run_vec(16'h0F00, 16'h0F00, 1'b0, "R3 group2 generate");
    run_vec(16'h0FF0, 16'h0010, 1'b0, "R3 chained groups");
    // Both bits set, XOR not OR (R5)
    run_vec(16'h5555, 16'h5555, 1'b0, "R5 doubled bits");
    run_vec(16'hAAAA, 16'hAAAA, 1'b1, "R5 doubled bits cin");
    // Full propagate (R6)
    run_vec(16'hFFFF, 16'h0000, 1'b1, "R6 all ones");
    run_vec(16'h5555, 16'hAAAA, 1'b1, "R6 alternating");
    run_vec(16'hFFFF, 16'hFFFF, 1'b1, "R6 max");
    run_vec(16'h5555, 16'hAAAA, 1'b0, "R6 no carry-in");
    // Top bit carry (R1)
    run_vec(16'h8000, 16'h8000, 1'b0, "R1 top bit");
    run_vec(16'h1234, 16'hEDCB, 1'b1, "R1 complement");
    // Walking carries (R4)
    for (int k = 0; k < 16; k++)
      run_vec(16'hFFFF >> k, 16'h0001, 1'b0, "R4 walking");
    // Random vectors (R1)
    for (int n = 0; n < 400; n++)
      run_vec(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule